// File: doc/BRIEF.md
# Hybrid Word-Parallel / Digit-Serial Decimal Adder

This unit adds or subtracts two 14-digit operands, each carried as a 56-bit vector of four-bit digits. In binary mode it performs a plain 56-bit add or subtract in a single cycle. In decimal mode it normally uses a word-wide adder: every digit is biased by six, the whole word is summed once, and each digit that produced no decimal carry has the six removed again. That path is exact only while every digit lies in 0 to 9. A digit from A through F would need two decimal carries out of one position, and the wide adder can carry only one.

A parallel scanner therefore inspects every digit of both operands on each decimal request. If any digit exceeds 9, the unit does not use the wide path. It loads the operands into a digit loop that resolves one digit per clock, least significant first, using the exact per-digit rule. The surrounding datapath issues a one-cycle `start` together with the mode, operation, carry-in and operands. It then waits for `done` and reads `result` and `cout`.

The controller has two states. `IDLE` accepts `start`. From `IDLE` it goes to `DIGIT_LOOP` on a decimal request whose operands hold a non-decimal digit. Every other request completes in place, and the state stays `IDLE`. `DIGIT_LOOP` returns to `IDLE` after its fourteenth digit step.

Top module: `bcd_hybrid_adder`

## Requirements
- R1: Digit i of an operand or result sits in bits 4i+3..4i. Digit 0 is the least significant, and decimal carries move from digit i to digit i+1.
- R2: Binary add (`dec_mode`=0, `sub`=0) gives {cout,result} = opa + opb + cin over 57 bits, with `done` high in the cycle after the accepting edge, whatever the digit values.
- R3: Binary subtract (`dec_mode`=0, `sub`=1) gives {cout,result} = opa + ~opb + cin, the ones' complement form. With cin=1 this is a true difference, and cout=1 means no borrow.
- R4: Decimal add forms s = a_i + b_i + c for each digit, starting with c = cin. If s >= 10 the digit is (s-10) mod 16 and the carry is 1; otherwise the digit is s and the carry is 0. cout is the carry out of digit 13.
- R5: Decimal subtract first replaces each digit of opb with (9 - b_i) mod 16, the nines' complement, and then applies the R4 rule.
- R6: A decimal request whose digits are all 0 to 9 completes with `done` in the cycle after the accepting edge, and `busy` never rises.
- R7: A decimal request with any digit above 9 in either operand raises `busy` from the accepting edge for 14 cycles. `done` is registered on the 14th edge after the accepting edge, and the result follows R4/R5.
- R8: `start` has no effect while `busy` is high. The running operation's result and timing are unchanged, and no extra `done` follows.
- R9: `done` is a one-cycle pulse per operation. `result` and `cout` change only together with `done` and hold otherwise.
- R10: After reset, `done`, `busy`, `cout` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted when not busy |
| dec_mode | input | 1 | 1 = decimal, 0 = binary |
| sub | input | 1 | 1 = subtract, 0 = add |
| cin | input | 1 | Carry in / borrow control |
| opa | input | 56 | First operand, 14 digits |
| opb | input | 56 | Second operand, 14 digits |
| busy | output | 1 | Digit loop running |
| done | output | 1 | Result valid pulse |
| result | output | 56 | Sum or difference |
| cout | output | 1 | Carry out of the top digit |

## Verification
The assertions assume that all inputs are two-state and that the operands, mode, operation and carry-in are valid in the cycle that `start` is high. They assume nothing about these inputs after that cycle. They also allow `start` to arrive while the loop runs. The bench changes inputs only on falling edges and releases `start` after one cycle. It deliberately raises `start` during a running loop to exercise R8, and it mixes fully decimal operands with operands that carry injected A to F digits.

// File: rtl/bcd_hybrid_pkg.sv
package bcd_hybrid_pkg;
    localparam int DIG_W = 4;

    typedef enum logic {
        S_IDLE,
        S_DIGIT_LOOP
    } ctl_state_t;

    function automatic logic [DIG_W-1:0] nines(input logic [DIG_W-1:0] d);
        return 4'd9 - d;
    endfunction
endpackage

// File: rtl/bcd_nondec_scan.sv
module bcd_nondec_scan
    import bcd_hybrid_pkg::*;
#(
    parameter int NDIG = 14
) (
    input  logic [NDIG*DIG_W-1:0] a,
    input  logic [NDIG*DIG_W-1:0] b,
    output logic                  found
);
    logic [NDIG-1:0] over;

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        assign over[i] = (a[i*DIG_W +: DIG_W] > 4'd9) || (b[i*DIG_W +: DIG_W] > 4'd9);
    end

    assign found = |over;
endmodule

// File: rtl/bcd_par_add.sv
module bcd_par_add
    import bcd_hybrid_pkg::*;
#(
    parameter int NDIG = 14
) (
    input  logic [NDIG*DIG_W-1:0] a,
    input  logic [NDIG*DIG_W-1:0] b,
    input  logic                  cin,
    output logic [NDIG*DIG_W-1:0] sum,
    output logic                  cout
);
    localparam int W = NDIG * DIG_W;
    localparam logic [W-1:0] BIAS = {NDIG{4'h6}};

    logic [W:0]      raw;
    logic [NDIG-1:0] dcar;

    assign raw = {1'b0, a} + {1'b0, b} + {1'b0, BIAS} + {{W{1'b0}}, cin};

    for (genvar i = 0; i < NDIG; i++) begin : g_fix
        if (i < NDIG - 1) begin : g_mid
            // bias bit at a digit boundary is zero, so carry = raw ^ a ^ b
            assign dcar[i] = raw[i*DIG_W + DIG_W] ^ a[i*DIG_W + DIG_W] ^ b[i*DIG_W + DIG_W];
        end else begin : g_top
            assign dcar[i] = raw[W];
        end
        assign sum[i*DIG_W +: DIG_W] = dcar[i] ? raw[i*DIG_W +: DIG_W]
                                               : raw[i*DIG_W +: DIG_W] - 4'd6;
    end

    assign cout = raw[W];
endmodule

// File: rtl/bcd_digit_step.sv
module bcd_digit_step
    import bcd_hybrid_pkg::*;
(
    input  logic [DIG_W-1:0] a,
    input  logic [DIG_W-1:0] b,
    input  logic             cin,
    output logic [DIG_W-1:0] d,
    output logic             cout
);
    logic [DIG_W:0] s;

    always_comb begin
        s = {1'b0, a} + {1'b0, b} + {4'd0, cin};
        if (s >= 5'd10) begin
            d    = 4'(s - 5'd10);
            cout = 1'b1;
        end else begin
            d    = s[DIG_W-1:0];
            cout = 1'b0;
        end
    end

    // decimal inputs must always give a decimal digit (R4)
    always_comb begin
        if (a <= 4'd9 && b <= 4'd9) begin
            assert_digit_decimal_R4: assert (d <= 4'd9);
        end
    end
endmodule

// File: rtl/bcd_hybrid_adder.sv
module bcd_hybrid_adder
    import bcd_hybrid_pkg::*;
#(
    parameter int NDIG = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  dec_mode,
    input  logic                  sub,
    input  logic                  cin,
    input  logic [NDIG*DIG_W-1:0] opa,
    input  logic [NDIG*DIG_W-1:0] opb,
    output logic                  busy,
    output logic                  done,
    output logic [NDIG*DIG_W-1:0] result,
    output logic                  cout
);
    localparam int W  = NDIG * DIG_W;
    localparam int IW = (NDIG > 1) ? $clog2(NDIG) : 1;
    localparam int LW = $clog2(NDIG + 1) + 1;

    ctl_state_t     st, st_nx;
    logic [IW-1:0]  idx;
    logic [W-1:0]   acc_a, acc_b;
    logic [W-5:0]   acc_r;
    logic           c_run;

    logic [W-1:0]   b_dec;
    logic           nondec, use_loop, accept, last_step;
    logic [W-1:0]   par_sum;
    logic           par_c;
    logic [W:0]     bin_full;
    logic [DIG_W-1:0] step_d;
    logic           step_c;
    logic [W-1:0]   loop_word;

    // operand B conditioning for decimal subtract
    for (genvar i = 0; i < NDIG; i++) begin : g_nine
        assign b_dec[i*DIG_W +: DIG_W] = sub ? nines(opb[i*DIG_W +: DIG_W])
                                             : opb[i*DIG_W +: DIG_W];
    end

    bcd_nondec_scan #(.NDIG(NDIG)) u_scan (
        .a(opa), .b(opb), .found(nondec)
    );

    bcd_par_add #(.NDIG(NDIG)) u_par (
        .a(opa), .b(b_dec), .cin(cin), .sum(par_sum), .cout(par_c)
    );

    bcd_digit_step u_step (
        .a(acc_a[DIG_W-1:0]), .b(acc_b[DIG_W-1:0]), .cin(c_run),
        .d(step_d), .cout(step_c)
    );

    assign bin_full  = {1'b0, opa} + {1'b0, sub ? ~opb : opb} + {{W{1'b0}}, cin};
    assign use_loop  = dec_mode & nondec;
    assign busy      = (st == S_DIGIT_LOOP);
    assign accept    = start & ~busy;
    assign last_step = (idx == IW'(NDIG - 1));
    assign loop_word = {step_d, acc_r};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:       if (accept && use_loop) st_nx = S_DIGIT_LOOP;
            S_DIGIT_LOOP: if (last_step)          st_nx = S_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            acc_a  <= '0;
            acc_b  <= '0;
            acc_r  <= '0;
            c_run  <= 1'b0;
            result <= '0;
            cout   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    if (accept) begin
                        if (use_loop) begin
                            acc_a <= opa;
                            acc_b <= b_dec;
                            c_run <= cin;
                            idx   <= '0;
                        end else begin
                            result <= dec_mode ? par_sum : bin_full[W-1:0];
                            cout   <= dec_mode ? par_c   : bin_full[W];
                            done   <= 1'b1;
                        end
                    end
                end
                S_DIGIT_LOOP: begin
                    acc_a <= acc_a >> DIG_W;
                    acc_b <= acc_b >> DIG_W;
                    acc_r <= loop_word[W-1:DIG_W];
                    c_run <= step_c;
                    idx   <= idx + 1'b1;
                    if (last_step) begin
                        result <= loop_word;
                        cout   <= step_c;
                        done   <= 1'b1;
                    end
                end
            endcase
        end
    end

    // ---------------- assertions ----------------
    logic [LW-1:0] run_len;
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    assert_fast_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && dec_mode && !nondec) |=> (done && !busy));
    assert_bin_no_loop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !dec_mode) |=> (done && !busy));
    assert_fallback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && dec_mode && nondec) |=> (busy && !done));
    assert_loop_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && run_len == LW'(NDIG)));
    assert_no_done_mid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(cout)));
endmodule

// File: tb/bcd_hybrid_adder_tb.sv
module bcd_hybrid_adder_tb;
    localparam int NDIG = 14;
    localparam int W    = NDIG * 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         dec_mode = 1'b0;
    logic         sub = 1'b0;
    logic         cin = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         busy, done, cout;
    logic [W-1:0] result;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 0;

    always #4 clk = ~clk;

    bcd_hybrid_adder #(.NDIG(NDIG)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dec_mode(dec_mode),
        .sub(sub), .cin(cin), .opa(opa), .opb(opb),
        .busy(busy), .done(done), .result(result), .cout(cout)
    );

    function automatic logic [W:0] ref_calc(bit dm, bit sb, bit c,
                                            logic [W-1:0] a, logic [W-1:0] b);
        logic [W-1:0] r;
        int cc;
        if (!dm) return {1'b0, a} + {1'b0, sb ? ~b : b} + {{W{1'b0}}, c};
        cc = c;
        for (int i = 0; i < NDIG; i++) begin
            int ad, bd, s;
            ad = a[i*4 +: 4];
            bd = b[i*4 +: 4];
            if (sb) bd = (9 - bd) & 15;
            s = ad + bd + cc;
            if (s >= 10) begin r[i*4 +: 4] = 4'((s - 10) & 15); cc = 1; end
            else         begin r[i*4 +: 4] = 4'(s);             cc = 0; end
        end
        return {cc[0], r};
    endfunction

    function automatic bit has_nondec(logic [W-1:0] a, logic [W-1:0] b);
        for (int i = 0; i < NDIG; i++)
            if (a[i*4 +: 4] > 9 || b[i*4 +: 4] > 9) return 1;
        return 0;
    endfunction

    function automatic logic [W-1:0] rand_dec();
        logic [W-1:0] v;
        for (int i = 0; i < NDIG; i++) v[i*4 +: 4] = 4'($urandom % 10);
        return v;
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // launch one request, wait for done, check timing and value
    task automatic run_op(string req, bit dm, bit sb, bit c,
                          logic [W-1:0] a, logic [W-1:0] b);
        logic [W:0] exp;
        int lat_exp, n;
        exp     = ref_calc(dm, sb, c, a, b);
        lat_exp = (dm && has_nondec(a, b)) ? 14 : 0;
        @(negedge clk);
        dec_mode = dm; sub = sb; cin = c; opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(req, "busy after accept", 64'(busy), 64'(lat_exp != 0));
        n = 0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(req, "latency", 64'(n), 64'(lat_exp));
        check(req, "result", 64'(result), 64'(exp[W-1:0]));
        check(req, "cout", 64'(cout), 64'(exp[W]));
    endtask

    task automatic t_reset();
        check("R10", "done", 64'(done), 64'd0);
        check("R10", "busy", 64'(busy), 64'd0);
        check("R10", "result", 64'(result), 64'd0);
        check("R10", "cout", 64'(cout), 64'd0);
    endtask

    task automatic t_binary();
        run_op("R2", 0, 0, 0, 56'hFF_FFFF_FFFF_FFFF, 56'h1);
        run_op("R2", 0, 0, 1, 56'hAB_CDEF_0123_4567, 56'h0F_EDCB_A987_6543);
        run_op("R3", 0, 1, 1, 56'h5, 56'h3);
        run_op("R3", 0, 1, 1, 56'h3, 56'h5);
        run_op("R3", 0, 1, 0, 56'hEE_0000_0000_0000, 56'hE);
    endtask

    task automatic t_dec_fast();
        run_op("R1", 1, 0, 0, 56'h99_9999_9999_9999, 56'h1);
        run_op("R4", 1, 0, 1, 56'h12_3456_7890_1234, 56'h98_7654_3210_9876);
        for (int k = 0; k < 20; k++) run_op("R6", 1, 0, k[0], rand_dec(), rand_dec());
    endtask

    task automatic t_dec_sub();
        run_op("R5", 1, 1, 1, 56'h5, 56'h3);
        run_op("R5", 1, 1, 1, 56'h3, 56'h5);
        for (int k = 0; k < 10; k++) run_op("R5", 1, 1, 1, rand_dec(), rand_dec());
    endtask

    task automatic t_dec_loop();
        run_op("R7", 1, 0, 0, 56'hF, 56'hF);
        run_op("R7", 1, 0, 1, 56'hEE_EEEE_EEEE_EEEE, 56'h11_1111_1111_1111);
        run_op("R7", 1, 1, 1, 56'h1234, 56'hF0);
        for (int k = 0; k < 12; k++) begin
            logic [W-1:0] a, b;
            int p;
            a = rand_dec();
            b = rand_dec();
            p = $urandom % NDIG;
            if (k[0]) a[p*4 +: 4] = 4'(10 + $urandom % 6);
            else      b[p*4 +: 4] = 4'(10 + $urandom % 6);
            run_op("R7", 1, k[1], k[2], a, b);
        end
    endtask

    task automatic t_busy_ignore();
        logic [W:0] exp;
        int n;
        exp = ref_calc(1, 0, 0, 56'hF1, 56'h22);
        @(negedge clk);
        dec_mode = 1; sub = 0; cin = 0; opa = 56'hF1; opb = 56'h22; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        repeat (4) begin @(negedge clk); n++; end
        opa = 56'h1; opb = 56'h1; start = 1'b1;   // fast request while busy
        @(negedge clk); n++;
        start = 1'b0;
        while (!done && n < 40) begin @(negedge clk); n++; end
        check("R8", "latency", 64'(n), 64'd14);
        check("R8", "result", 64'(result), 64'(exp[W-1:0]));
        @(negedge clk);
        check("R8", "no extra done", 64'(done), 64'd0);
        check("R8", "idle", 64'(busy), 64'd0);
    endtask

    task automatic t_hold();
        logic [W-1:0] r0;
        logic c0;
        run_op("R9", 1, 0, 0, 56'h45, 56'h67);
        r0 = result; c0 = cout;
        opa = 56'hFF; opb = 56'hAA; dec_mode = 0;
        repeat (3) @(negedge clk);
        check("R9", "done pulse", 64'(done), 64'd0);
        check("R9", "result held", 64'(result), 64'(r0));
        check("R9", "cout held", 64'(cout), 64'(c0));
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_binary();
        t_dec_fast();
        t_dec_sub();
        t_dec_loop();
        t_busy_ignore();
        t_hold();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule